// File: doc/BRIEF.md
# Write-Completion Poller

This block sits on the controller side of a nonvolatile memory port. It watches a program or erase operation on the host side until the operation finishes. A command issuer pulses `start_i` when it begins a command sequence, and it passes the detection mode, the operation kind, the target address, the expected data word and a poll budget with that pulse. The poller then counts the issuer's write strobes. It does not read until the last strobe of the sequence has gone by. After that it reads the target location over a request/acknowledge read port, one read at a time, until the status bits show that the internal write has ended.

The end of an internal write is not synchronised to the host. A single status sample taken at the instant of completion can therefore look finished while the rest of the word is still in flux. For that reason the poller never decides on one sample. Each apparent completion must hold for two further reads before it is accepted. A failed confirmation returns the poller to ordinary polling. Once completion is confirmed, the poller waits a settle interval, then takes one last full-word read and compares it with the expected data. The result comes out as a one-cycle `done_o` pulse, together with a held pass flag and a held timeout flag.

Top module: `wr_done_poller`

## Requirements
- R1: After reset, `rd_req_o`, `busy_o`, `done_o`, `pass_o` and `timeout_o` are all low.
- R2: In idle, `start_i` captures `mode_i`, `op_i`, `expect_i`, `addr_i` and `max_polls_i`. A `start_i` pulse while `busy_o` is high is ignored and changes neither the run nor its result.
- R3: After a start, no read is requested until `wstb_i` has pulsed 4 times for a program (`op_i`=0) or 6 times for an erase (`op_i`=1).
- R4: `rd_req_o` stays high until a cycle with `rd_ack_i` high, so only one read is outstanding at a time. `rd_addr_o` equals the captured address on every read.
- R5: In data-polling mode (`mode_i`=0), a read counts as a completion candidate when data bit 7 equals bit 7 of the expected word for a program, or when data bit 7 is 1 for an erase.
- R6: In toggle mode (`mode_i`=1), a read counts as a completion candidate when its bit 6 equals bit 6 of the read just before it. The first read of a run is never a candidate.
- R7: A candidate is accepted only if the next two reads also meet the same criterion. If either of them fails, polling resumes with a fresh read.
- R8: After an accepted completion, at least `SETTLE_CYC` clock cycles pass with no read requested before the final read is issued.
- R9: The final read's full data word is compared with the captured expected word. `pass_o` is 1 exactly when they are equal.
- R10: If the number of detection reads (poll plus confirm) has reached the captured budget when a fresh poll read would be due, the run ends with `timeout_o`=1 and `pass_o`=0, and no further reads are made.
- R11: `done_o` is a one-cycle pulse. `busy_o` is low in that cycle. `pass_o` and `timeout_o` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (accepted only when idle) |
| mode_i | input | 1 | 0 = data polling on bit 7, 1 = toggle on bit 6 |
| op_i | input | 1 | 0 = program, 1 = erase |
| expect_i | input | DW | Expected data word |
| addr_i | input | AW | Location to poll |
| max_polls_i | input | CW | Budget of detection reads |
| wstb_i | input | 1 | One pulse per write strobe of the command sequence |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid in the same cycle |
| rd_data_i | input | DW | Read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Final word matched the expected word |
| timeout_o | output | 1 | Run ended because the poll budget ran out |

## Verification
The hardest case to reach is a status sample that looks finished while the write is still running. A correct device produces it only when a read happens to coincide with completion. The bench device model is driven by read index, and it can return completion-looking status on chosen reads inside the busy window. Two consecutive false completions followed by a busy read show that both confirming reads are needed. The settle wait is checked by measuring the idle gap between the last confirming acknowledge and the final request.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARM    = 3'd1,
        ST_POLL   = 3'd2,
        ST_CONF   = 3'd3,
        ST_SETTLE = 3'd4,
        ST_FINAL  = 3'd5
    } wdp_state_e;

    typedef enum logic {
        MODE_DATA   = 1'b0,
        MODE_TOGGLE = 1'b1
    } wdp_mode_e;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } wdp_op_e;

endpackage

// File: rtl/wdp_strobe_gate.sv
module wdp_strobe_gate
    import wdp_pkg::*;
#(
    parameter int PROG_STROBES  = 4,
    parameter int ERASE_STROBES = 6
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear_i,
    input  wdp_op_e op_i,
    input  logic    stb_i,
    output logic    ready_o
);
    localparam int MAXS = (PROG_STROBES > ERASE_STROBES) ? PROG_STROBES : ERASE_STROBES;
    localparam int SBW  = $clog2(MAXS + 1);

    typedef struct packed {
        logic [SBW-1:0] cnt;
    } gate_t;

    gate_t          s_d, s_q;
    logic [SBW-1:0] need;

    always_comb begin
        need = (op_i == OP_ERASE) ? SBW'(ERASE_STROBES) : SBW'(PROG_STROBES);
        s_d  = s_q;
        if (clear_i) begin
            s_d.cnt = '0;
        end else if (stb_i && (s_q.cnt < need)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready_o = (s_q.cnt == need);

    // R3: the strobe count never passes the larger of the two sequence lengths
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= SBW'(MAXS));

endmodule

// File: rtl/wdp_judge.sv
module wdp_judge
    import wdp_pkg::*;
(
    input  wdp_mode_e mode_i,
    input  wdp_op_e   op_i,
    input  logic      exp_poll_bit_i,
    input  logic      poll_bit_i,
    input  logic      tog_bit_i,
    input  logic      prev_tog_i,
    input  logic      have_prev_i,
    output logic      hit_o
);
    always_comb begin
        if (mode_i == MODE_DATA) begin
            if (op_i == OP_ERASE) hit_o = poll_bit_i;
            else                  hit_o = (poll_bit_i == exp_poll_bit_i);
        end else begin
            hit_o = have_prev_i && (tog_bit_i == prev_tog_i);
        end
    end
endmodule

// File: rtl/wdp_settle_timer.sv
module wdp_settle_timer #(
    parameter int SETTLE_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic running_o,
    output logic expired_o
);
    localparam int TW = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        logic          run;
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.run = 1'b1;
            s_d.cnt = (SETTLE_CYC > 0) ? TW'(SETTLE_CYC - 1) : '0;
        end else if (s_q.run) begin
            if (s_q.cnt == '0) s_d.run = 1'b0;
            else               s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign running_o = s_q.run;
    assign expired_o = s_q.run && (s_q.cnt == '0);

    // R8: a load always starts a wait
    p_load_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> running_o);

endmodule

// File: rtl/wr_done_poller.sv
module wr_done_poller
    import wdp_pkg::*;
#(
    parameter int DW            = 16,
    parameter int AW            = 20,
    parameter int CW            = 16,
    parameter int SETTLE_CYC    = 250,
    parameter int POLL_BIT      = 7,
    parameter int TOGGLE_BIT    = 6,
    parameter int PROG_STROBES  = 4,
    parameter int ERASE_STROBES = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic          op_i,
    input  logic [DW-1:0] expect_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] max_polls_i,
    input  logic          wstb_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          pass_o,
    output logic          timeout_o
);
    localparam int CONFIRMS = 2;
    localparam int CFW      = $clog2(CONFIRMS + 1);

    typedef struct packed {
        wdp_state_e     st;
        wdp_mode_e      mode;
        wdp_op_e        op;
        logic [DW-1:0]  expv;
        logic [AW-1:0]  addr;
        logic [CW-1:0]  maxp;
        logic [CW-1:0]  polls;
        logic           prev_tog;
        logic           have_prev;
        logic [CFW-1:0] conf_left;
        logic           req;
        logic           done;
        logic           pass;
        logic           tmo;
    } ctl_t;

    ctl_t        s_d, s_q;
    logic        start_acc;
    logic        gate_ready;
    logic        hit;
    logic        settle_load;
    logic        settle_run;
    logic        settle_exp;
    logic [CW:0] polls_next;
    logic        out_of_budget;

    assign start_acc = start_i && (s_q.st == ST_IDLE);

    wdp_strobe_gate #(
        .PROG_STROBES (PROG_STROBES),
        .ERASE_STROBES(ERASE_STROBES)
    ) gate_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(start_acc),
        .op_i   (s_q.op),
        .stb_i  (wstb_i),
        .ready_o(gate_ready)
    );

    wdp_judge judge_i (
        .mode_i        (s_q.mode),
        .op_i          (s_q.op),
        .exp_poll_bit_i(s_q.expv[POLL_BIT]),
        .poll_bit_i    (rd_data_i[POLL_BIT]),
        .tog_bit_i     (rd_data_i[TOGGLE_BIT]),
        .prev_tog_i    (s_q.prev_tog),
        .have_prev_i   (s_q.have_prev),
        .hit_o         (hit)
    );

    wdp_settle_timer #(
        .SETTLE_CYC(SETTLE_CYC)
    ) settle_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (settle_load),
        .running_o(settle_run),
        .expired_o(settle_exp)
    );

    assign polls_next    = {1'b0, s_q.polls} + 1'b1;
    assign out_of_budget = (polls_next >= {1'b0, s_q.maxp});

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        settle_load = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st        = ST_ARM;
                    s_d.mode      = wdp_mode_e'(mode_i);
                    s_d.op        = wdp_op_e'(op_i);
                    s_d.expv      = expect_i;
                    s_d.addr      = addr_i;
                    s_d.maxp      = max_polls_i;
                    s_d.polls     = '0;
                    s_d.have_prev = 1'b0;
                    s_d.prev_tog  = 1'b0;
                    s_d.conf_left = '0;
                    s_d.pass      = 1'b0;
                    s_d.tmo       = 1'b0;
                end
            end

            ST_ARM: begin
                if (gate_ready) begin
                    s_d.st  = ST_POLL;
                    s_d.req = 1'b1;
                end
            end

            ST_POLL, ST_CONF: begin
                if (rd_ack_i) begin
                    s_d.req       = 1'b0;
                    s_d.polls     = polls_next[CW-1:0];
                    s_d.prev_tog  = rd_data_i[TOGGLE_BIT];
                    s_d.have_prev = 1'b1;
                    if (hit && (s_q.st == ST_CONF) && (s_q.conf_left == CFW'(1))) begin
                        s_d.st      = ST_SETTLE;
                        settle_load = 1'b1;
                    end else if (hit) begin
                        s_d.st        = ST_CONF;
                        s_d.conf_left = (s_q.st == ST_CONF) ? s_q.conf_left - 1'b1
                                                            : CFW'(CONFIRMS);
                        s_d.req       = 1'b1;
                    end else if (out_of_budget) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.tmo  = 1'b1;
                        s_d.pass = 1'b0;
                    end else begin
                        s_d.st  = ST_POLL;
                        s_d.req = 1'b1;
                    end
                end
            end

            ST_SETTLE: begin
                if (settle_exp) begin
                    s_d.st  = ST_FINAL;
                    s_d.req = 1'b1;
                end
            end

            ST_FINAL: begin
                if (rd_ack_i) begin
                    s_d.req  = 1'b0;
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.pass = (rd_data_i == s_q.expv);
                end
            end

            default: begin
                s_d.st  = ST_IDLE;
                s_d.req = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.mode <= MODE_DATA;
            s_q.op   <= OP_PROG;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_req_o  = s_q.req;
    assign rd_addr_o = s_q.addr;
    assign busy_o    = (s_q.st != ST_IDLE);
    assign done_o    = s_q.done;
    assign pass_o    = s_q.pass;
    assign timeout_o = s_q.tmo;

    // R4: a request is held until it is acknowledged
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> rd_req_o);

    // R4: the address does not move while a read is pending
    p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> $stable(rd_addr_o));

    // R3: no read before the strobe gate opens
    p_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> gate_ready);

    // R8: the bus stays quiet during the settle wait
    p_settle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        settle_run |-> !rd_req_o);

    // R10: a timeout never reports success
    p_tmo_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !pass_o);

    // R11: done is a single-cycle pulse outside the busy window
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: tb/wr_done_poller_tb.sv
module wr_done_poller_tb_top;
    localparam int DW     = 16;
    localparam int AW     = 20;
    localparam int CW     = 16;
    localparam int SETTLE = 250;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic          op_i = 1'b0;
    logic [DW-1:0] expect_i = '0;
    logic [AW-1:0] addr_i = '0;
    logic [CW-1:0] max_polls_i = '0;
    logic          wstb_i = 1'b0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_ack_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          busy_o, done_o, pass_o, timeout_o;

    always #2 clk = ~clk;

    wr_done_poller #(.DW(DW), .AW(AW), .CW(CW), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .op_i(op_i),
        .expect_i(expect_i), .addr_i(addr_i), .max_polls_i(max_polls_i), .wstb_i(wstb_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .timeout_o(timeout_o)
    );

    int checks = 0;
    int errors = 0;

    // device model scenario
    logic          sc_mode, sc_op, sc_never;
    int            sc_busy, sc_g1, sc_g2;
    logic [DW-1:0] sc_final;
    logic [AW-1:0] sc_addr;

    // read port monitor state
    int  rd_count, addr_errs, max_gap, cyc, last_ack;
    bit  first_rd;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] model(input int k);
        logic fin, look, b7;
        fin = !sc_never && (k > sc_busy);
        if (sc_mode) begin
            if (fin) return sc_final;
            return (16'h2B00 | (k[0] ? 16'h0040 : 16'h0000));
        end
        if (fin && (k - sc_busy >= 4)) return sc_final;
        look = fin || (k == sc_g1) || (k == sc_g2);
        b7 = sc_op ? look : (look ? sc_final[7] : ~sc_final[7]);
        return (16'h0F0F & ~16'h0080) | {8'h00, b7, 7'h00};
    endfunction

    // responder: acts on falling edges only
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rd_ack_i) begin
                rd_ack_i = 1'b0;
            end else if (rd_req_o) begin
                rd_count++;
                if (rd_addr_o != sc_addr) addr_errs++;
                if (!first_rd && (cyc - last_ack > max_gap)) max_gap = cyc - last_ack;
                first_rd = 1'b0;
                last_ack = cyc;
                rd_data_i = model(rd_count);
                rd_ack_i = 1'b1;
            end
        end
    end

    task automatic set_scn(input logic m, input logic o, input int b, input int g1,
                           input int g2, input logic [DW-1:0] fin, input logic nev);
        sc_mode = m; sc_op = o; sc_busy = b; sc_g1 = g1; sc_g2 = g2;
        sc_final = fin; sc_never = nev;
        rd_count = 0; addr_errs = 0; max_gap = 0; first_rd = 1'b1;
    endtask

    task automatic do_start(input logic m, input logic o, input logic [DW-1:0] e,
                            input logic [AW-1:0] a, input logic [CW-1:0] mp);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; op_i = o; expect_i = e; addr_i = a; max_polls_i = mp;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wstb_i = 1'b1;
            @(negedge clk); wstb_i = 1'b0;
        end
    endtask

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done_o, tag, done_o, 1);
        chk(!busy_o, "R11 busy low with done", busy_o, 0);
    endtask

    task automatic after_done(input logic exp_pass, input logic exp_tmo);
        @(negedge clk);
        chk(!done_o, "R11 done one cycle", done_o, 0);
        repeat (10) @(negedge clk);
        chk(pass_o == exp_pass, "R11 pass held", pass_o, exp_pass);
        chk(timeout_o == exp_tmo, "R11 timeout held", timeout_o, exp_tmo);
    endtask

    task automatic t_reset();
        chk(!rd_req_o, "R1 req", rd_req_o, 0);
        chk(!busy_o, "R1 busy", busy_o, 0);
        chk(!done_o, "R1 done", done_o, 0);
        chk(!pass_o, "R1 pass", pass_o, 0);
        chk(!timeout_o, "R1 timeout", timeout_o, 0);
    endtask

    task automatic t_prog_poll();
        sc_addr = 20'h05A5A;
        set_scn(1'b0, 1'b0, 3, 0, 0, 16'h00A5, 1'b0);
        do_start(1'b0, 1'b0, 16'h00A5, sc_addr, 16'd100);
        strobes(4);
        wait_done("R5 program poll done");
        chk(pass_o, "R9 program pass", pass_o, 1);
        chk(!timeout_o, "R10 no timeout", timeout_o, 0);
        chk(rd_count == 7, "R5 program read count", rd_count, 7);
        chk(addr_errs == 0, "R4 address", addr_errs, 0);
        chk(max_gap >= SETTLE && max_gap <= SETTLE + 3, "R8 settle gap", max_gap, SETTLE + 1);
        after_done(1'b1, 1'b0);
    endtask

    task automatic t_glitch();
        sc_addr = 20'h00123;
        set_scn(1'b0, 1'b0, 6, 2, 3, 16'h00A5, 1'b0);
        do_start(1'b0, 1'b0, 16'h00A5, sc_addr, 16'd100);
        strobes(4);
        wait_done("R7 glitch done");
        chk(rd_count == 10, "R7 false completions rejected", rd_count, 10);
        chk(pass_o, "R7 pass after confirm", pass_o, 1);
    endtask

    task automatic t_erase();
        sc_addr = 20'h3F000;
        set_scn(1'b0, 1'b1, 2, 0, 0, 16'hFFFF, 1'b0);
        do_start(1'b0, 1'b1, 16'hFFFF, sc_addr, 16'd100);
        strobes(5);
        repeat (20) @(negedge clk);
        chk(rd_count == 0, "R3 no read before sixth strobe", rd_count, 0);
        strobes(1);
        wait_done("R5 erase done");
        chk(rd_count == 6, "R5 erase read count", rd_count, 6);
        chk(pass_o, "R9 erase pass", pass_o, 1);
    endtask

    task automatic t_toggle();
        sc_addr = 20'h0ABCD;
        set_scn(1'b1, 1'b0, 3, 0, 0, 16'h1234, 1'b0);
        do_start(1'b1, 1'b0, 16'h1234, sc_addr, 16'd100);
        strobes(4);
        repeat (3) @(negedge clk);
        // R2: start while busy must be ignored
        start_i = 1'b1; mode_i = 1'b0; op_i = 1'b1; expect_i = 16'h0000;
        addr_i = 20'h11111; max_polls_i = 16'd1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done("R6 toggle done");
        chk(rd_count == 8, "R6 toggle read count", rd_count, 8);
        chk(pass_o, "R2 run unchanged by late start", pass_o, 1);
        chk(addr_errs == 0, "R2 address kept", addr_errs, 0);
        chk(max_gap >= SETTLE && max_gap <= SETTLE + 3, "R8 toggle settle", max_gap, SETTLE + 1);
    endtask

    task automatic t_mismatch();
        sc_addr = 20'h00777;
        set_scn(1'b0, 1'b0, 0, 0, 0, 16'h00A4, 1'b0);
        do_start(1'b0, 1'b0, 16'h00A5, sc_addr, 16'd100);
        strobes(4);
        wait_done("R9 mismatch done");
        chk(rd_count == 4, "R9 mismatch read count", rd_count, 4);
        chk(!pass_o, "R9 word mismatch fails", pass_o, 0);
        chk(!timeout_o, "R9 not a timeout", timeout_o, 0);
    endtask

    task automatic t_timeout();
        sc_addr = 20'h00042;
        set_scn(1'b0, 1'b0, 0, 0, 0, 16'h0080, 1'b1);
        do_start(1'b0, 1'b0, 16'h0080, sc_addr, 16'd5);
        strobes(4);
        wait_done("R10 timeout done");
        chk(timeout_o, "R10 timeout flag", timeout_o, 1);
        chk(!pass_o, "R10 pass low", pass_o, 0);
        chk(rd_count == 5, "R10 reads within budget", rd_count, 5);
        after_done(1'b0, 1'b1);
        chk(rd_count == 5, "R10 no reads after timeout", rd_count, 5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        sc_addr = '0;
        set_scn(1'b0, 1'b0, 0, 0, 0, '0, 1'b0);
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_prog_poll();
        t_glitch();
        t_erase();
        t_toggle();
        t_mismatch();
        t_timeout();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule